// File: doc/BRIEF.md
# Stuffed Serial Frame Receiver

The receiver sits behind a clock-recovery stage that hands it one recovered line bit at a time, each marked by a valid strobe. It undoes the transmitter's zero-run stuffing. After six zeros in a row the transmitter always inserts a one, and the receiver drops that one. Stuffing applies everywhere on the line: in idle gaps, in headers and in payloads. Once stuffing is removed, the receiver hunts for a marker of three ones in a row. It then reads a 16-bit header, which carries a frame type and a word count. After the header it collects the payload into 16-bit words, each marked by a one-cycle strobe, ready to be pushed into a FIFO.

When a frame ends, a done pulse reports the frame type and length. If the line shows a zero where a stuffed one was due, the receiver flags a stuff error, drops any partial frame and goes back to hunting for the marker.

Top module: `stuffed_frame_rx`

## Requirements
- R1: When six zeros in a row have been accepted, the next valid bit, if it is a one, is discarded and never reaches the parser. Every accepted one clears the zero-run count, and so does a discarded one.
- R2: If the bit after six zeros is a zero, `stuff_err_o` pulses for one cycle right after the clock edge that samples it. That bit is not delivered, the zero-run count clears, and any partial frame is dropped without a done pulse. Reception resumes at the next marker.
- R3: While hunting, three delivered ones in a row form the start marker, and the next delivered bit is the first header bit, even when it is a one. One or two ones followed by a zero start nothing.
- R4: The header is received most-significant bit first. Header bits 15..12 are the frame type. Bits 11..10 are ignored. Bits 9..0 are the length in 16-bit words.
- R5: A frame carries exactly length × 16 payload bits. Each word is presented MSB first, so the first payload bit received becomes bit 15. `word_vld_o` pulses for one cycle, one edge after the edge that samples the word's last bit.
- R6: `frame_done_o` pulses one cycle after the last word's strobe, never in the same cycle as a word strobe. During that pulse `frame_type_o` and `frame_len_o` hold the header fields.
- R7: A length of zero ends the frame straight after the header. No word strobe occurs, and `frame_done_o` pulses two edges after the edge that samples the last header bit.
- R8: Idle zeros of any length, with stuffing applied, produce no output. Cycles with `bit_vld_i` low have no effect, so gaps between bits do not change the received words.
- R9: After reset all outputs are zero.
- R10: A frame of maximum length 1023 with an all-zero payload is received as 1023 zero words with the correct length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_i | input | 1 | Recovered line bit |
| bit_vld_i | input | 1 | `bit_i` is valid this cycle |
| word_o | output | 16 | Payload word |
| word_vld_o | output | 1 | One-cycle strobe for `word_o` |
| frame_done_o | output | 1 | One-cycle pulse after a frame completes |
| frame_type_o | output | 4 | Type field of the latest header |
| frame_len_o | output | 10 | Length field of the latest header |
| stuff_err_o | output | 1 | One-cycle pulse on a missing stuffed one |

## Verification
Each result has a fixed latency, counted in edges from the edge that samples the line bit causing it. A stuff error shows right after that same edge. A word strobe follows one edge later, and the done pulse two edges later. The bench stamps every driven data bit with a cycle count, and stamps every output event on the falling edge. It then compares the stamps of the last word, the done pulse and the error pulse against these offsets, in addition to checking the word values and counts.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } rxf_state_e;
endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxf_destuff.sv
module rxf_destuff #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic vld_i,
  output logic bit_o,
  output logic vld_o,
  output logic err_o
);
  localparam int ZW = $clog2(RUN_LEN + 1);
  localparam logic [ZW-1:0] RUN_Z = ZW'(RUN_LEN);

  logic [ZW-1:0] zcnt_q, zcnt_d;
  logic          bit_q, bit_d;
  logic          vld_q, vld_d;
  logic          err_q, err_d;

  always_comb begin
    zcnt_d = zcnt_q;
    bit_d  = bit_q;
    vld_d  = 1'b0;
    err_d  = 1'b0;
    if (vld_i) begin
      if (zcnt_q == RUN_Z) begin
        // slot of a stuffed one: drop it, or flag its absence
        zcnt_d = '0;
        err_d  = ~bit_i;
      end else begin
        vld_d  = 1'b1;
        bit_d  = bit_i;
        zcnt_d = bit_i ? '0 : zcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q <= '0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      zcnt_q <= zcnt_d;
      bit_q  <= bit_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
  assign err_o = err_q;
endmodule

// File: rtl/rxf_sync_det.sv
module rxf_sync_det #(
  parameter int SYNC_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt_i,
  input  logic clr_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int CW = $clog2(SYNC_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(SYNC_LEN - 1);

  logic [CW-1:0] ones_q, ones_d;

  assign hit_o = hunt_i & vld_i & bit_i & (ones_q == LAST);

  always_comb begin
    ones_d = ones_q;
    if (!hunt_i || clr_i) begin
      ones_d = '0;
    end else if (vld_i) begin
      if (!bit_i || hit_o) ones_d = '0;
      else                 ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end
endmodule

// File: rtl/rxf_deframe.sv
module rxf_deframe
  import rxf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int TYPE_W = 4,
  parameter int PAD_W  = 2,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              bit_i,
  input  logic              err_i,
  input  logic              hit_i,
  output logic              hunt_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              done_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int HDR_W = TYPE_W + PAD_W + LEN_W;
  localparam int SH_W  = (HDR_W > WORD_W) ? HDR_W : WORD_W;
  localparam int BW    = $clog2(SH_W);
  localparam logic [BW-1:0]    HDR_LAST  = BW'(HDR_W - 1);
  localparam logic [BW-1:0]    WORD_LAST = BW'(WORD_W - 1);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);

  rxf_state_e        st_q, st_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [LEN_W-1:0]  wcnt_q, wcnt_d;
  logic [TYPE_W-1:0] type_q, type_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              wvld_q, wvld_d;
  logic              fin_q, fin_d;
  logic              done_q;

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    wcnt_d = wcnt_q;
    type_d = type_q;
    len_d  = len_q;
    word_d = word_q;
    wvld_d = 1'b0;
    fin_d  = 1'b0;
    if (err_i) begin
      st_d   = ST_HUNT;
      bcnt_d = '0;
    end else if (vld_i) begin
      unique case (st_q)
        ST_HUNT: begin
          if (hit_i) begin
            st_d   = ST_HDR;
            bcnt_d = '0;
          end
        end
        ST_HDR: begin
          sh_d = {sh_q[SH_W-2:0], bit_i};
          if (bcnt_q == HDR_LAST) begin
            bcnt_d = '0;
            wcnt_d = '0;
            type_d = sh_d[HDR_W-1 -: TYPE_W];
            len_d  = sh_d[LEN_W-1:0];
            if (len_d == '0) begin
              fin_d = 1'b1;
              st_d  = ST_HUNT;
            end else begin
              st_d  = ST_PAY;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        ST_PAY: begin
          sh_d = {sh_q[SH_W-2:0], bit_i};
          if (bcnt_q == WORD_LAST) begin
            bcnt_d = '0;
            word_d = sh_d[WORD_W-1:0];
            wvld_d = 1'b1;
            if (wcnt_q == len_q - LEN_ONE) begin
              fin_d = 1'b1;
              st_d  = ST_HUNT;
            end else begin
              wcnt_d = wcnt_q + 1'b1;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      bcnt_q <= '0;
      sh_q   <= '0;
      wcnt_q <= '0;
      type_q <= '0;
      len_q  <= '0;
      word_q <= '0;
      wvld_q <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      wcnt_q <= wcnt_d;
      type_q <= type_d;
      len_q  <= len_d;
      word_q <= word_d;
      wvld_q <= wvld_d;
      fin_q  <= fin_d;
      done_q <= fin_q;
    end
  end

  assign hunt_o     = (st_q == ST_HUNT);
  assign word_o     = word_q;
  assign word_vld_o = wvld_q;
  assign done_o     = done_q;
  assign type_o     = type_q;
  assign len_o      = len_q;
endmodule

// File: rtl/stuffed_frame_rx.sv
module stuffed_frame_rx #(
  parameter int RUN_LEN  = 6,
  parameter int SYNC_LEN = 3,
  parameter int WORD_W   = 16,
  parameter int TYPE_W   = 4,
  parameter int PAD_W    = 2,
  parameter int LEN_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              frame_done_o,
  output logic [TYPE_W-1:0] frame_type_o,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              stuff_err_o
);
  logic rst_s_n;
  logic ds_bit, ds_vld, ds_err;
  logic hunt, hit;

  rxf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rxf_destuff #(.RUN_LEN(RUN_LEN)) u_ds (
    .clk   (clk),
    .rst_n (rst_s_n),
    .bit_i (bit_i),
    .vld_i (bit_vld_i),
    .bit_o (ds_bit),
    .vld_o (ds_vld),
    .err_o (ds_err)
  );

  rxf_sync_det #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .hunt_i (hunt),
    .clr_i  (ds_err),
    .vld_i  (ds_vld),
    .bit_i  (ds_bit),
    .hit_o  (hit)
  );

  rxf_deframe #(
    .WORD_W (WORD_W),
    .TYPE_W (TYPE_W),
    .PAD_W  (PAD_W),
    .LEN_W  (LEN_W)
  ) u_df (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .vld_i      (ds_vld),
    .bit_i      (ds_bit),
    .err_i      (ds_err),
    .hit_i      (hit),
    .hunt_o     (hunt),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .done_o     (frame_done_o),
    .type_o     (frame_type_o),
    .len_o      (frame_len_o)
  );

  assign stuff_err_o = ds_err;
endmodule

// File: rtl/stuffed_frame_rx_chk.sv
module stuffed_frame_rx_chk
  import rxf_pkg::*;
#(
  parameter int RUN_LEN = 6,
  parameter int LEN_W   = 10
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bit_i,
  input logic                           bit_vld_i,
  input logic [$clog2(RUN_LEN+1)-1:0]   zcnt,
  input logic                           ds_vld,
  input rxf_state_e                     st,
  input logic                           word_vld_o,
  input logic                           frame_done_o,
  input logic [LEN_W-1:0]               frame_len_o,
  input logic                           stuff_err_o
);
  localparam int ZW = $clog2(RUN_LEN + 1);
  localparam logic [ZW-1:0] RUN_Z = ZW'(RUN_LEN);

  p_stuff_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_i && bit_i && zcnt == RUN_Z) |=> !ds_vld);

  p_zrun_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    zcnt <= RUN_Z);

  p_err_hunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err_o |=> (st == ST_HUNT));

  p_word_from_pay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> ($past(st) == ST_PAY));

  p_done_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> ($past(word_vld_o) || frame_len_o == '0));

  p_done_word_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_vld_o, frame_done_o}));
endmodule

bind stuffed_frame_rx stuffed_frame_rx_chk #(.RUN_LEN(RUN_LEN), .LEN_W(LEN_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_s_n),
  .bit_i        (bit_i),
  .bit_vld_i    (bit_vld_i),
  .zcnt         (u_ds.zcnt_q),
  .ds_vld       (ds_vld),
  .st           (u_df.st_q),
  .word_vld_o   (word_vld_o),
  .frame_done_o (frame_done_o),
  .frame_len_o  (frame_len_o),
  .stuff_err_o  (stuff_err_o)
);

// File: tb/stuffed_frame_rx_tb_top.sv
module stuffed_frame_rx_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bit_i;
  logic        bit_vld_i;
  logic [15:0] word_o;
  logic        word_vld_o;
  logic        frame_done_o;
  logic [3:0]  frame_type_o;
  logic [9:0]  frame_len_o;
  logic        stuff_err_o;

  stuffed_frame_rx dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_i        (bit_i),
    .bit_vld_i    (bit_vld_i),
    .word_o       (word_o),
    .word_vld_o   (word_vld_o),
    .frame_done_o (frame_done_o),
    .frame_type_o (frame_type_o),
    .frame_len_o  (frame_len_o),
    .stuff_err_o  (stuff_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // output monitor, sampled on the falling edge
  logic [15:0] got [0:2047];
  int got_total = 0;
  int word_stamp = 0;
  int done_total = 0;
  int done_stamp = 0;
  logic [3:0] done_type = '0;
  logic [9:0] done_len = '0;
  int err_total = 0;
  int err_stamp = 0;

  always @(negedge clk) begin
    if (word_vld_o) begin
      if (got_total < 2048) got[got_total] = word_o;
      got_total++;
      word_stamp = cyc;
    end
    if (frame_done_o) begin
      done_total++;
      done_stamp = cyc;
      done_type  = frame_type_o;
      done_len   = frame_len_o;
    end
    if (stuff_err_o) begin
      err_total++;
      err_stamp = cyc;
    end
  end

  // driver state
  int tx_z = 0;
  int gap_g = 0;
  int bit_stamp = 0;
  int data_stamp = 0;
  logic [15:0] exp_w [0:1023];
  int w_base, d_base, e_base;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mark();
    w_base = got_total;
    d_base = done_total;
    e_base = err_total;
  endtask

  task automatic drive_raw(input logic b);
    for (int g = 0; g < gap_g; g++) begin
      @(negedge clk);
      bit_vld_i = 1'b0;
    end
    @(negedge clk);
    bit_i = b;
    bit_vld_i = 1'b1;
    @(posedge clk);
    #1;
    bit_stamp = cyc;
    bit_vld_i = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    drive_raw(b);
    data_stamp = bit_stamp;
    if (b) tx_z = 0;
    else   tx_z++;
    if (tx_z == 6) begin
      drive_raw(1'b1);
      tx_z = 0;
    end
  endtask

  task automatic send_field(input logic [15:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_frame(input logic [3:0] ty, input logic [1:0] pad, input logic [9:0] len);
    send_field(16'h7, 3);
    send_field({ty, pad, len}, 16);
    for (int i = 0; i < int'(len); i++) send_field(exp_w[i], 16);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input logic [3:0] ty, input logic [9:0] len);
    chk(got_total - w_base == int'(len), req, got_total - w_base, len);
    for (int i = 0; i < int'(len); i++)
      if (got[w_base + i] != exp_w[i]) chk(0, req, got[w_base + i], exp_w[i]);
    chk(done_total - d_base == 1, {req, " done count"}, done_total - d_base, 1);
    chk(done_type == ty, {req, " type"}, done_type, ty);
    chk(done_len == len, {req, " length"}, done_len, len);
  endtask

  // R9
  task automatic t_reset();
    chk(word_vld_o == 0 && frame_done_o == 0 && stuff_err_o == 0, "R9 strobes",
        {word_vld_o, frame_done_o, stuff_err_o}, 0);
    chk(frame_type_o == 0 && frame_len_o == 0 && word_o == 0, "R9 fields",
        {frame_type_o, frame_len_o, word_o}, 0);
  endtask

  // R4 R5 R6 R1: words with long zero runs, ignored pad bits set
  task automatic t_basic();
    mark();
    idle(10);
    exp_w[0] = 16'hA5C3;
    exp_w[1] = 16'h0300;
    exp_w[2] = 16'h8001;
    send_frame(4'h5, 2'b11, 10'd3);
    wait_cyc(5);
    check_frame("R4 R5 R1 basic", 4'h5, 10'd3);
    chk(word_stamp == data_stamp + 1, "R5 word latency", word_stamp - data_stamp, 1);
    chk(done_stamp == data_stamp + 2, "R6 done latency", done_stamp - data_stamp, 2);
  endtask

  // R3: header starting with ones straight after the marker
  task automatic t_type_ones();
    mark();
    idle(4);
    exp_w[0] = 16'hFFFF;
    send_frame(4'hF, 2'b00, 10'd1);
    wait_cyc(5);
    check_frame("R3 ones after marker", 4'hF, 10'd1);
  endtask

  // R7
  task automatic t_len0();
    mark();
    idle(7);
    send_frame(4'h9, 2'b01, 10'd0);
    wait_cyc(5);
    chk(got_total == w_base, "R7 no words", got_total - w_base, 0);
    chk(done_total - d_base == 1, "R7 done", done_total - d_base, 1);
    chk(done_stamp == data_stamp + 2, "R7 done latency", done_stamp - data_stamp, 2);
    chk(done_type == 4'h9, "R7 type", done_type, 9);
  endtask

  // R3: short runs of ones in idle do not start a frame
  task automatic t_false_sync();
    mark();
    idle(3);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0);
    idle(30);
    wait_cyc(5);
    chk(got_total == w_base && done_total == d_base, "R3 no false marker",
        (got_total - w_base) + (done_total - d_base), 0);
    exp_w[0] = 16'h7FFE;
    send_frame(4'h3, 2'b10, 10'd1);
    wait_cyc(5);
    check_frame("R3 after short runs", 4'h3, 10'd1);
  endtask

  // R8: long idle and gaps in the valid strobe
  task automatic t_idle_gap();
    mark();
    idle(45);
    wait_cyc(4);
    chk(got_total == w_base && done_total == d_base && err_total == e_base, "R8 idle quiet",
        (got_total - w_base) + (done_total - d_base) + (err_total - e_base), 0);
    gap_g = 3;
    exp_w[0] = 16'h1234;
    exp_w[1] = 16'h0040;
    send_frame(4'hC, 2'b00, 10'd2);
    gap_g = 0;
    wait_cyc(5);
    check_frame("R8 gapped frame", 4'hC, 10'd2);
  endtask

  // R2: missing stuffed one in idle and inside a payload
  task automatic t_stuff_err();
    mark();
    tx_z = 0;
    send_bit(1'b1);
    for (int i = 0; i < 6; i++) drive_raw(1'b0);
    drive_raw(1'b0);
    tx_z = 0;
    wait_cyc(3);
    chk(err_total - e_base == 1, "R2 idle error count", err_total - e_base, 1);
    chk(err_stamp == bit_stamp, "R2 error latency", err_stamp - bit_stamp, 0);
    mark();
    send_field(16'h7, 3);
    send_field({4'h6, 2'b00, 10'd4}, 16);
    send_field(16'h8001, 16);
    for (int i = 0; i < 6; i++) drive_raw(1'b0);
    drive_raw(1'b0);
    tx_z = 0;
    wait_cyc(6);
    chk(err_total - e_base == 1, "R2 payload error", err_total - e_base, 1);
    chk(got_total - w_base == 1 && got[w_base] == 16'h8001, "R2 partial words",
        got_total - w_base, 1);
    chk(done_total == d_base, "R2 aborted frame no done", done_total - d_base, 0);
    mark();
    idle(8);
    exp_w[0] = 16'hC0DE;
    exp_w[1] = 16'h0001;
    send_frame(4'h2, 2'b00, 10'd2);
    wait_cyc(5);
    check_frame("R2 recovery", 4'h2, 10'd2);
  endtask

  // R10 R1: maximum length, all-zero payload
  task automatic t_max_zero();
    int bad;
    mark();
    idle(5);
    for (int i = 0; i < 1024; i++) exp_w[i] = 16'h0000;
    send_frame(4'h0, 2'b00, 10'd1023);
    wait_cyc(5);
    bad = 0;
    for (int i = 0; i < 1023; i++) if (got[w_base + i] != 16'h0000) bad++;
    chk(got_total - w_base == 1023, "R10 word count", got_total - w_base, 1023);
    chk(bad == 0, "R10 R1 zero words", bad, 0);
    chk(done_len == 10'd1023 && done_total - d_base == 1, "R10 done length", done_len, 1023);
    chk(err_total == e_base, "R1 no stuff error", err_total - e_base, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bit_i = 1'b0;
    bit_vld_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_type_ones();
    t_len0();
    t_false_sync();
    t_idle_gap();
    t_stuff_err();
    t_max_zero();
    wait_cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule